// File: doc/BRIEF.md
# Robbed-Bit Signaling Transmit Inserter

This block places per-channel signaling bits into the outgoing T1 byte stream. Software writes the signaling state of all 24 channels into a bank of twelve 8-bit registers. At every multiframe boundary the whole bank is copied into a shadow store. While insertion is enabled, the shadow bits replace the least significant bit of each channel byte in the signaling frames. Because the copy happens only at the boundary, a write made partway through a multiframe never changes the multiframe that is already being sent.

The framer around the block supplies the channel byte, the frame number (1 to 24), the channel number (0 to 23), a strobe that marks the first byte of each multiframe, a mode select (extended superframe or the 12-frame superframe) and a global enable. Each boundary sets a sticky status flag, which tells software that it may write the next set of values. Software clears the flag with a write-one pulse.

Top module: `rbs_tx_insert`

## Requirements
- R1: Reset clears the output byte, the status flag, all twelve registers and the shadow store to zero. If the first multiframe after reset runs with no register writes, a 0 is inserted in every signaling position.
- R2: Register address r (0 to 11) maps to signaling type r/3 (0 = A, 1 = B, 2 = C or second A, 3 = D or second B) for channels 8*(r%3) to 8*(r%3)+7, and bit b holds channel 8*(r%3)+b. Writes to addresses 12 to 15 are ignored.
- R3: On the clock edge where mf_strobe is high, the shadow store takes the register contents. Register writes at any other time do not change the bits inserted before the next strobe.
- R4: With esf_mode = 1 and insertion enabled, bit 0 of each channel byte is replaced by the shadow A bit in frame 6, the B bit in frame 12, the C bit in frame 18 and the D bit in frame 24.
- R5: With esf_mode = 0 and insertion enabled, only frames 6 (A) and 12 (B) are modified. Every other frame number, including 18 and 24, passes through unchanged.
- R6: With ins_en = 0, every byte passes through unchanged.
- R7: Bits 7 to 1 of every byte always pass through unchanged. Bytes in frames that carry no signaling pass through whole.
- R8: tx_mf_flag goes to 1 on the edge after a cycle in which mf_strobe is high and stays at 1 until a cycle in which flag_clr is high. If mf_strobe and flag_clr are high in the same cycle, the flag ends up set.
- R9: ch_byte_out shows the result for the inputs that were sampled on the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| flag_clr | input | 1 | Write-one clear of the status flag |
| ch_byte_in | input | 8 | Outgoing channel byte |
| frame_num | input | 5 | Frame number within the multiframe, 1 to 24 |
| chan_num | input | 5 | Channel number, 0 to 23 |
| mf_strobe | input | 1 | High with the first byte of a multiframe |
| esf_mode | input | 1 | 1 = 24-frame mode with four bits, 0 = 12-frame mode with two bits |
| ins_en | input | 1 | Global insertion enable |
| ch_byte_out | output | 8 | Channel byte after insertion |
| tx_mf_flag | output | 1 | Sticky multiframe-boundary status |

## Verification
Every byte result is due on the first rising edge after its inputs are applied. The driver pushes the expected byte for each input it applies, and the monitor pops one item one time step after the next rising edge, so every comparison also checks the single cycle of latency. The status flag is sampled on the falling edge after the edge that sets or clears it. The shadow-load rule is checked by writing registers in the middle of a multiframe and expecting the previous values to keep appearing until the next strobe.

// File: rtl/rbs_tx_insert.sv
module rbs_tx_insert #(
  parameter int NUM_CH = 24,
  parameter int FRAMES = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              flag_clr,
  input  logic [BYTE_W-1:0] ch_byte_in,
  input  logic [4:0]        frame_num,
  input  logic [4:0]        chan_num,
  input  logic              mf_strobe,
  input  logic              esf_mode,
  input  logic              ins_en,
  output logic [BYTE_W-1:0] ch_byte_out,
  output logic              tx_mf_flag
);
  localparam int RPG   = NUM_CH / 8;
  localparam int NREG  = 4 * RPG;
  localparam int SH_W  = 4 * NUM_CH;
  localparam int STEP  = FRAMES / 4;
  localparam int IDX_W = $clog2(SH_W);

  logic [7:0]      regs [NREG];
  logic [SH_W-1:0] reg_flat;
  logic [SH_W-1:0] shadow;
  logic [1:0]      sig_sel;
  logic            sig_hit;
  logic [IDX_W-1:0] sig_idx;
  logic            live;

  for (genvar r = 0; r < NREG; r++) begin : g_flat
    assign reg_flat[r*8 +: 8] = regs[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else if (wr_en && int'(wr_addr) < NREG) begin
      regs[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow <= '0;
    else if (mf_strobe) shadow <= reg_flat;
  end

  always_comb begin
    sig_sel = 2'd0;
    sig_hit = 1'b0;
    if (int'(frame_num) == STEP) begin
      sig_sel = 2'd0; sig_hit = 1'b1;
    end else if (int'(frame_num) == 2*STEP) begin
      sig_sel = 2'd1; sig_hit = 1'b1;
    end else if (esf_mode && int'(frame_num) == 3*STEP) begin
      sig_sel = 2'd2; sig_hit = 1'b1;
    end else if (esf_mode && int'(frame_num) == 4*STEP) begin
      sig_sel = 2'd3; sig_hit = 1'b1;
    end
    if (int'(chan_num) >= NUM_CH) sig_hit = 1'b0;
  end

  assign sig_idx = IDX_W'(int'(sig_sel) * NUM_CH + int'(chan_num));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ch_byte_out <= '0;
    else if (ins_en && sig_hit)
      ch_byte_out <= {ch_byte_in[BYTE_W-1:1], shadow[sig_idx]};
    else
      ch_byte_out <= ch_byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_mf_flag <= 1'b0;
    else if (mf_strobe) tx_mf_flag <= 1'b1;
    else if (flag_clr)  tx_mf_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  assert_upper_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> ch_byte_out[BYTE_W-1:1] == $past(ch_byte_in[BYTE_W-1:1]));

  assert_disabled_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(ins_en)) |-> ch_byte_out == $past(ch_byte_in));

  assert_d4_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(esf_mode) && ($past(frame_num) == 5'(3*STEP) || $past(frame_num) == 5'(4*STEP)))
      |-> ch_byte_out == $past(ch_byte_in));

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(mf_strobe)) |-> $stable(shadow));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(mf_strobe)) |-> tx_mf_flag);

  assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $rose(tx_mf_flag)) |-> $past(mf_strobe));

endmodule

// File: tb/rbs_tx_insert_tb.sv
module rbs_tx_insert_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       flag_clr = 1'b0;
  logic [7:0] ch_byte_in = '0;
  logic [4:0] frame_num = 5'd1;
  logic [4:0] chan_num = '0;
  logic       mf_strobe = 1'b0;
  logic       esf_mode = 1'b1;
  logic       ins_en = 1'b0;
  logic [7:0] ch_byte_out;
  logic       tx_mf_flag;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t q[$];

  logic [7:0]  m_regs [12];
  logic [95:0] m_sh;

  always #5 clk = ~clk;

  rbs_tx_insert u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_clr(flag_clr), .ch_byte_in(ch_byte_in), .frame_num(frame_num),
    .chan_num(chan_num), .mf_strobe(mf_strobe), .esf_mode(esf_mode),
    .ins_en(ins_en), .ch_byte_out(ch_byte_out), .tx_mf_flag(tx_mf_flag)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, ch_byte_out, e.val);
    end
  end

  function automatic logic [7:0] model(logic [7:0] b, int f, int c);
    int sel;
    sel = -1;
    if (f == 6) sel = 0;
    else if (f == 12) sel = 1;
    else if (esf_mode && f == 18) sel = 2;
    else if (esf_mode && f == 24) sel = 3;
    if (!ins_en || sel < 0) return b;
    return {b[7:1], m_sh[sel*24 + c]};
  endfunction

  task automatic drive(logic [7:0] b, int f, int c, logic strb, logic clr, string tag);
    exp_t e;
    @(negedge clk);
    wr_en = 1'b0; ch_byte_in = b; frame_num = 5'(f); chan_num = 5'(c);
    mf_strobe = strb; flag_clr = clr;
    e.val = model(b, f, c); e.tag = tag;
    q.push_back(e);
    if (strb) for (int r = 0; r < 12; r++) m_sh[r*8 +: 8] = m_regs[r];
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; mf_strobe = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    mf_strobe = 1'b0; flag_clr = 1'b0;
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    if (a < 12) m_regs[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sweep(string tag);
    for (int f = 1; f <= 24; f++)
      for (int c = 0; c < 24; c++)
        drive(8'((f * 37) ^ (c * 11) ^ 8'h5A), f, c, (f == 1 && c == 0), 1'b0, tag);
    idle();
  endtask

  task automatic check_flag(string tag, logic exp);
    @(negedge clk);
    check(tag, {7'd0, tx_mf_flag}, {7'd0, exp});
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 12; r++) m_regs[r] = '0;
    m_sh = '0;
    repeat (3) @(negedge clk);
    check("R1 out", ch_byte_out, 8'h00);
    check("R1 flag", {7'd0, tx_mf_flag}, 8'h00);
    rst_n = 1'b1;
    ins_en = 1'b1; esf_mode = 1'b1;

    sweep("R1");
    check_flag("R8 set", 1'b1);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    check("R8 clr", {7'd0, tx_mf_flag}, 8'h00);

    for (int r = 0; r < 12; r++) wr(r, 8'((r * 8'h3B) ^ 8'hA6));
    for (int c = 0; c < 24; c++) drive(8'hFF, 6, c, 1'b0, 1'b0, "R3");
    for (int c = 0; c < 24; c++) drive(8'hFF, 24, c, 1'b0, 1'b0, "R3");
    idle();

    sweep("R4");
    sweep("R4");

    wr(0, 8'h00); wr(4, 8'hFF); wr(11, 8'h5A);
    for (int c = 0; c < 24; c++) drive(8'h80, 6, c, 1'b0, 1'b0, "R3");
    for (int c = 0; c < 24; c++) drive(8'h01, 12, c, 1'b0, 1'b0, "R3");
    idle();
    sweep("R4");

    esf_mode = 1'b0;
    sweep("R5");
    ins_en = 1'b0;
    sweep("R6");
    ins_en = 1'b1;
    sweep("R7");
    esf_mode = 1'b1;

    wr(12, 8'hFF); wr(13, 8'hFF); wr(15, 8'hFF);
    sweep("R2");

    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    check("R8 clr2", {7'd0, tx_mf_flag}, 8'h00);
    drive(8'h42, 1, 0, 1'b1, 1'b1, "R8");
    idle();
    check("R8 set wins", {7'd0, tx_mf_flag}, 8'h01);

    drive(8'h12, 1, 5, 1'b0, 1'b0, "R9");
    drive(8'h34, 1, 6, 1'b0, 1'b0, "R9");
    drive(8'hC3, 6, 7, 1'b0, 1'b0, "R9");
    idle();
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule